// File: doc/BRIEF.md
# Banked External Event Interrupt Controller

This block collects a parameterized number of external event lines, grouped into banks of 32, and turns each of them into one masked interrupt request. A build-time capability vector decides how each event behaves. A configurable event runs its synchronized input through rising and falling edge detectors. Each detector sets its own sticky pending flag, and software clears a flag by writing 1 to it. A direct event skips the pending logic: its synchronized level, gated by the mask, goes straight to the output.

Software reaches the block through a plain 32-bit register port. Writes take effect on the clock edge where `bus_wr` is high, and reads are combinational from `bus_addr`. The port has no handshake, so it never applies back-pressure: every write is accepted in the cycle it is presented, and read data is valid in the same cycle as the address. Some events can be reserved for another owner, either through a security vector or through a per-event owner field whose ID differs from the local owner (ID 1). Writes from this port cannot touch the control or pending bits of a reserved event.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Event n is handled by bank n/32 at bit n%32. Bank b occupies byte addresses b*0x20 to b*0x20+0x1F, with registers at these offsets: rise enable 0x00, fall enable 0x04, software trigger 0x08, rising pending 0x0C, falling pending 0x10, mask 0x14, capability 0x18, security 0x1C. An address with bits 1:0 not zero reads 0 and is never written.
- R2: On a configurable event with its rise enable set, a 0-to-1 change of the synchronized input sets its bit in the rising pending register.
- R3: On a configurable event with its fall enable set, a 1-to-0 change sets its bit in the falling pending register. With both enables set, a pulse sets both flags, each in its own register.
- R4: In either pending register, writing 1 to a bit clears it and writing 0 leaves it unchanged.
- R5: Writing 1 to a bit of the software trigger register sets that configurable event's rising pending bit. The register always reads 0.
- R6: For a configurable event, irq_o is (rising pending OR falling pending) AND mask. A pending event with a mask bit of 0 gives no interrupt.
- R7: For a direct event (capability bit 0), irq_o is the synchronized input AND mask. Its pending bits stay 0, even after a software trigger.
- R8: The capability register (1 = configurable) and the security register (1 = reserved) read their build-time values and ignore writes.
- R9: An event is reserved when its security bit is set, or when owner filtering is present and its owner filter is on with an owner ID other than 1. Writes to a reserved event's rise enable, fall enable, mask, software trigger or pending bits have no effect.
- R10: Owner word n sits at 0x180+4*n, with the filter enable in bit 0 and the owner ID in bits 6:4. The word at 0x3F0 holds the owner-ID width (3) in bits 27:24, or 0 when owner filtering is absent. In that case owner words read 0 and reserve nothing.
- R11: If an edge sets a pending bit in the same cycle that a write-1 clears it, the bit ends up set.
- R12: After reset every enable, mask and pending bit is 0 and irq_o is 0. A configurable event's input change shows on irq_o after three clock edges: two synchronizer stages, then the pending flop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | NUM_BANKS*32 | Raw event inputs, asynchronous to clk |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | NUM_BANKS*32 | Masked interrupt request per event |

## Verification
The bench drives an edge in exactly the cycle that a write-1 clear of the same pending bit lands. A design that gives the clear priority would lose that interrupt and read the bit back as 0. It writes zeros to a set pending bit, which catches a plain register write masquerading as write-one-to-clear. It pokes direct events with edges and software triggers, which exposes pending flops leaking into pass-through events. Finally, it writes all ones to registers of banks that hold secure and foreign-owned events, which reveals a reserved-bit filter that is missing or keyed to the wrong owner ID.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int EVT_PER_BANK = 32;
  localparam int BANK_BYTES   = 32;
  localparam int OWN_BASE     = 'h180;
  localparam int HWCFG_ADDR   = 'h3F0;
  localparam int OWN_ID_W     = 3;
  localparam int LOCAL_OWNER  = 1;

  typedef enum logic [2:0] {
    REG_RISE  = 3'd0,
    REG_FALL  = 3'd1,
    REG_SWI   = 3'd2,
    REG_RPEND = 3'd3,
    REG_FPEND = 3'd4,
    REG_MASK  = 3'd5,
    REG_CAP   = 3'd6,
    REG_SEC   = 3'd7
  } bank_reg_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_o    <= '0;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/evt_bank.sv
module evt_bank
  import evt_pkg::*;
#(
  parameter int W = EVT_PER_BANK
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  bank_reg_e reg_sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ev_s,
  input  logic [W-1:0] cap,
  input  logic [W-1:0] resv,
  output logic [W-1:0] rise_en,
  output logic [W-1:0] fall_en,
  output logic [W-1:0] rpend,
  output logic [W-1:0] fpend,
  output logic [W-1:0] mask,
  output logic [W-1:0] irq
);
  logic [W-1:0] prev_s;
  logic [W-1:0] wr_bits, rise_hit, fall_hit;
  logic [W-1:0] rp_clr, fp_clr, swi_set;

  always_comb begin
    wr_bits  = wdata & ~resv;
    rise_hit = ev_s & ~prev_s & rise_en;
    fall_hit = ~ev_s & prev_s & fall_en;
    rp_clr   = (wr_en && reg_sel == REG_RPEND) ? wr_bits : '0;
    fp_clr   = (wr_en && reg_sel == REG_FPEND) ? wr_bits : '0;
    swi_set  = (wr_en && reg_sel == REG_SWI)   ? wr_bits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_s  <= '0;
      rise_en <= '0;
      fall_en <= '0;
      mask    <= '0;
      rpend   <= '0;
      fpend   <= '0;
    end else begin
      prev_s <= ev_s;
      if (wr_en && reg_sel == REG_RISE) rise_en <= (rise_en & resv) | wr_bits;
      if (wr_en && reg_sel == REG_FALL) fall_en <= (fall_en & resv) | wr_bits;
      if (wr_en && reg_sel == REG_MASK) mask    <= (mask & resv) | wr_bits;
      // a new detection outranks a same-cycle clear
      rpend <= ((rpend & ~rp_clr) | rise_hit | swi_set) & cap;
      fpend <= ((fpend & ~fp_clr) | fall_hit) & cap;
    end
  end

  always_comb irq = (((rpend | fpend) & cap) | (ev_s & ~cap)) & mask;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 10,
  parameter logic [NUM_BANKS*EVT_PER_BANK-1:0] TRIG_CAP = '1,
  parameter logic [NUM_BANKS*EVT_PER_BANK-1:0] SECURE   = '0,
  parameter bit HAS_OWNER = 1'b1,
  parameter logic [NUM_BANKS*EVT_PER_BANK-1:0] OWN_EN   = '0,
  parameter logic [NUM_BANKS*EVT_PER_BANK*OWN_ID_W-1:0] OWN_ID = '0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_BANKS*EVT_PER_BANK-1:0] ev_i,
  input  logic                              bus_wr,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [31:0]                       bus_wdata,
  output logic [31:0]                       bus_rdata,
  output logic [NUM_BANKS*EVT_PER_BANK-1:0] irq_o
);
  localparam int NUM_EVT   = NUM_BANKS * EVT_PER_BANK;
  localparam int EVT_IDX_W = $clog2(NUM_EVT);
  localparam int SEL_W     = ADDR_W - 5;
  localparam int WORD_W    = ADDR_W - 2;
  localparam logic [WORD_W-1:0] OWN_WBASE = WORD_W'(OWN_BASE / 4);

  logic [NUM_EVT-1:0] ev_s, resv, cap_v, sec_v, own_en_a;
  logic [NUM_EVT-1:0][OWN_ID_W-1:0] own_id_a;
  logic [NUM_EVT-1:0] q_rise, q_fall, q_rpend, q_fpend, q_mask;

  logic              aligned, in_bank_area, in_own_area, is_hwcfg;
  logic [SEL_W-1:0]  bank_sel;
  logic [WORD_W-1:0] own_word;
  bank_reg_e         reg_sel;

  evt_sync #(.W(NUM_EVT)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ev_i), .q_o(ev_s)
  );

  for (genvar n = 0; n < NUM_EVT; n++) begin : g_evt_cfg
    assign cap_v[n]    = TRIG_CAP[n];
    assign sec_v[n]    = SECURE[n];
    assign own_en_a[n] = HAS_OWNER & OWN_EN[n];
    assign own_id_a[n] = HAS_OWNER ? OWN_ID[n*OWN_ID_W +: OWN_ID_W] : '0;
    assign resv[n]     = SECURE[n] |
                         (own_en_a[n] && own_id_a[n] != OWN_ID_W'(LOCAL_OWNER));
  end

  always_comb begin
    aligned      = (bus_addr[1:0] == 2'b00);
    bank_sel     = bus_addr[ADDR_W-1:5];
    reg_sel      = bank_reg_e'(bus_addr[4:2]);
    in_bank_area = aligned && (int'(bus_addr) < OWN_BASE) &&
                   (int'(bank_sel) < NUM_BANKS);
    own_word     = bus_addr[ADDR_W-1:2] - OWN_WBASE;
    in_own_area  = aligned && HAS_OWNER && (int'(bus_addr) >= OWN_BASE) &&
                   (int'(own_word) < NUM_EVT);
    is_hwcfg     = (bus_addr == ADDR_W'(HWCFG_ADDR));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_wr && in_bank_area && (int'(bank_sel) == b);

    evt_bank #(.W(EVT_PER_BANK)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr),
      .reg_sel (reg_sel),
      .wdata   (bus_wdata),
      .ev_s    (ev_s   [b*EVT_PER_BANK +: EVT_PER_BANK]),
      .cap     (cap_v  [b*EVT_PER_BANK +: EVT_PER_BANK]),
      .resv    (resv   [b*EVT_PER_BANK +: EVT_PER_BANK]),
      .rise_en (q_rise [b*EVT_PER_BANK +: EVT_PER_BANK]),
      .fall_en (q_fall [b*EVT_PER_BANK +: EVT_PER_BANK]),
      .rpend   (q_rpend[b*EVT_PER_BANK +: EVT_PER_BANK]),
      .fpend   (q_fpend[b*EVT_PER_BANK +: EVT_PER_BANK]),
      .mask    (q_mask [b*EVT_PER_BANK +: EVT_PER_BANK]),
      .irq     (irq_o  [b*EVT_PER_BANK +: EVT_PER_BANK])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (in_bank_area) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (int'(bank_sel) == b) begin
          case (reg_sel)
            REG_RISE:  bus_rdata = q_rise [b*EVT_PER_BANK +: EVT_PER_BANK];
            REG_FALL:  bus_rdata = q_fall [b*EVT_PER_BANK +: EVT_PER_BANK];
            REG_RPEND: bus_rdata = q_rpend[b*EVT_PER_BANK +: EVT_PER_BANK];
            REG_FPEND: bus_rdata = q_fpend[b*EVT_PER_BANK +: EVT_PER_BANK];
            REG_MASK:  bus_rdata = q_mask [b*EVT_PER_BANK +: EVT_PER_BANK];
            REG_CAP:   bus_rdata = cap_v  [b*EVT_PER_BANK +: EVT_PER_BANK];
            REG_SEC:   bus_rdata = sec_v  [b*EVT_PER_BANK +: EVT_PER_BANK];
            default:   bus_rdata = '0;
          endcase
        end
      end
    end else if (in_own_area) begin
      bus_rdata = {25'd0, own_id_a[own_word[EVT_IDX_W-1:0]], 3'd0,
                   own_en_a[own_word[EVT_IDX_W-1:0]]};
    end else if (is_hwcfg && HAS_OWNER) begin
      bus_rdata = 32'(OWN_ID_W) << 24;
    end
  end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 10,
  parameter int NUM_EVT   = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [NUM_EVT-1:0] ev_s,
  input logic [NUM_EVT-1:0] cap_v,
  input logic [NUM_EVT-1:0] resv,
  input logic [NUM_EVT-1:0] q_rise,
  input logic [NUM_EVT-1:0] q_fall,
  input logic [NUM_EVT-1:0] q_rpend,
  input logic [NUM_EVT-1:0] q_fpend,
  input logic [NUM_EVT-1:0] q_mask,
  input logic [NUM_EVT-1:0] irq_o
);
  logic [NUM_EVT-1:0] prev_s, rise_now, fall_now, clr_r, clr_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_s <= '0;
    else        prev_s <= ev_s;
  end

  assign rise_now = ev_s & ~prev_s & q_rise & cap_v;
  assign fall_now = ~ev_s & prev_s & q_fall & cap_v;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_clr
    assign clr_r[b*32 +: 32] = (bus_wr && bus_addr == ADDR_W'(b*32 + 'hC))  ? bus_wdata : '0;
    assign clr_f[b*32 +: 32] = (bus_wr && bus_addr == ADDR_W'(b*32 + 'h10)) ? bus_wdata : '0;
  end

  // R2 and R11: a qualified rising edge leaves its pending bit set
  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_rpend & $past(rise_now)) == $past(rise_now)));

  // R3 and R11
  p_fall_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_fpend & $past(fall_now)) == $past(fall_now)));

  // R4: bits not written with 1 are kept
  p_w1c_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_rpend & $past(q_rpend & ~clr_r)) == $past(q_rpend & ~clr_r)) &&
             ((q_fpend & $past(q_fpend & ~clr_f)) == $past(q_fpend & ~clr_f)));

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~q_mask) == '0);

  p_direct_no_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_rpend | q_fpend) & ~cap_v) == '0);

  p_resv_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_rise | q_fall | q_mask | q_rpend | q_fpend) & resv) == '0);
endmodule

bind evt_irq_ctrl evt_irq_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ev_s(ev_s), .cap_v(cap_v), .resv(resv),
  .q_rise(q_rise), .q_fall(q_fall), .q_rpend(q_rpend), .q_fpend(q_fpend),
  .q_mask(q_mask), .irq_o(irq_o)
);

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
  localparam int NB = 2;
  localparam int NE = NB * 32;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] ev_i = '0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NE-1:0] irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct { logic [NE-1:0] exp; string tag; } irq_item_t;
  irq_item_t exp_q[$];

  always #5 clk = ~clk;

  evt_irq_ctrl #(
    .NUM_BANKS(NB), .ADDR_W(AW),
    .TRIG_CAP({2{32'h0000_FFFF}}),
    .SECURE(64'h0000_0008_0000_0000),
    .HAS_OWNER(1'b1),
    .OWN_EN(64'h30),
    .OWN_ID(192'hA000)
  ) i_evt_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  // monitor: pops expected interrupt vectors and compares them
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      irq_item_t it;
      it = exp_q.pop_front();
      n_tests++;
      if (irq_o !== it.exp) begin
        n_fail++;
        $display("FAIL %s irq_o=%h expected=%h", it.tag, irq_o, it.exp);
      end
    end
  end

  task automatic expect_irq(input logic [NE-1:0] e, input string tag);
    irq_item_t it;
    it.exp = e;
    it.tag = tag;
    exp_q.push_back(it);
    while (exp_q.size() != 0) @(posedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = AW'(a);
    #1;
    n_tests++;
    if (bus_rdata !== e) begin
      n_fail++;
      $display("FAIL %s addr=%h rdata=%h expected=%h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    expect_irq('0, "R12 reset irq");
    rd_chk('h00, 0, "R12 rise enable after reset");
    rd_chk('h14, 0, "R12 mask after reset");
    rd_chk('h3F0, 32'h0300_0000, "R10 owner width word");
    rd_chk('h18, 32'h0000_FFFF, "R8 capability bank0");
    rd_chk('h3C, 32'h0000_0008, "R8 security bank1");
    wr('h18, 0);
    rd_chk('h18, 32'h0000_FFFF, "R8 capability ignores write");

    // rising edge and latency
    wr('h00, 32'h1);
    wr('h14, 32'h45);
    @(negedge clk); ev_i[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    expect_irq('0, "R12 not yet after two edges");
    expect_irq(64'h1, "R12/R2 irq after third edge");
    rd_chk('h0C, 32'h1, "R2 rising pending");
    rd_chk('h10, 32'h0, "R3 falling pending untouched by rise");

    // write-one-to-clear
    wr('h0C, 32'h0);
    rd_chk('h0C, 32'h1, "R4 write zero keeps");
    wr('h0C, 32'h1);
    rd_chk('h0C, 32'h0, "R4 write one clears");
    expect_irq('0, "R4 irq gone");

    // falling edge and both edges
    wr('h04, 32'h3);
    ev_i[0] = 1'b0; settle();
    rd_chk('h10, 32'h1, "R3 falling pending");
    rd_chk('h0C, 32'h0, "R3 rising stays clear");
    expect_irq(64'h1, "R6 irq from falling pending");
    wr('h10, 32'h1);
    wr('h00, 32'h3);
    ev_i[1] = 1'b1; settle();
    ev_i[1] = 1'b0; settle();
    rd_chk('h0C, 32'h2, "R3 both edges rising");
    rd_chk('h10, 32'h2, "R3 both edges falling");
    expect_irq('0, "R6 masked pending gives no irq");
    wr('h14, 32'h47);
    expect_irq(64'h2, "R6 unmasked pending");
    wr('h0C, 32'h2);
    wr('h10, 32'h2);
    expect_irq('0, "R4 both cleared");

    // software trigger
    wr('h08, 32'h40);
    rd_chk('h0C, 32'h40, "R5 swi sets rising pending");
    rd_chk('h08, 32'h0, "R5 swi reads zero");
    expect_irq(64'h40, "R5 swi irq");
    wr('h0C, 32'h40);

    // direct event 20
    wr('h14, 32'h0010_0047);
    wr('h00, 32'h0010_0003);
    ev_i[20] = 1'b1; settle();
    expect_irq(64'h0010_0000, "R7 direct level passes");
    rd_chk('h0C, 32'h0, "R7 direct no pending");
    ev_i[20] = 1'b0; settle();
    expect_irq('0, "R7 direct follows low");
    wr('h08, 32'h0010_0000);
    rd_chk('h0C, 32'h0, "R7 swi on direct ignored");
    expect_irq('0, "R7 swi on direct no irq");

    // reserved events
    wr('h34, 32'hFFFF_FFFF);
    rd_chk('h34, 32'hFFFF_FFF7, "R9 secure mask bit locked");
    wr('h20, 32'hFFFF_FFFF);
    rd_chk('h20, 32'hFFFF_FFF7, "R9 secure rise bit locked");
    wr('h28, 32'h8);
    rd_chk('h2C, 32'h0, "R9 swi on secure event ignored");
    wr('h14, 32'h0010_0077);
    rd_chk('h14, 32'h0010_0067, "R9 owner reserved bit4 locked, bit5 free");

    // owner words
    rd_chk('h190, 32'h21, "R10 owner word event4");
    rd_chk('h194, 32'h11, "R10 owner word event5");
    rd_chk('h180, 32'h0, "R10 owner word event0");
    rd_chk('h280, 32'h0, "R10 past last owner word");

    // set wins over clear, event 7
    wr('h00, 32'h0010_0083);
    @(negedge clk); ev_i[7] = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'('h0C); bus_wdata = 32'h80;
    @(negedge clk); bus_wr = 1'b0;
    rd_chk('h0C, 32'h80, "R11 set beats clear");
    wr('h0C, 32'h80);
    rd_chk('h0C, 32'h0, "R4 later clear works");

    // bank mapping: event 40 is bank1 bit8
    ev_i[40] = 1'b1; settle();
    rd_chk('h2C, 32'h100, "R1 event40 in bank1 bit8");
    expect_irq(64'h1 << 40, "R1 event40 irq");
    rd_chk('h2D, 32'h0, "R1 unaligned read zero");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule